// File: doc/BRIEF.md
# Strided Move-In DMA Engine

This engine carries out one move-in command at a time. Each command brings a 64-bit base address, a 64-bit packed parameter word and a reorder tag. The parameter word names a destination bank, a row count and a stride. The engine then reads that many 128-bit beats from external memory, one request in flight at a time. Row `i` is fetched from `base + i*16*stride`, and a zero stride is treated as one.

Once the last beat is in, the collected rows leave as a single bank write pulse. The engine then models the transfer time by waiting a fixed number of cycles per row. After that wait it raises a one-cycle commit carrying the reorder tag and becomes ready for the next command.

A command whose row count is zero, or larger than the row buffer holds, cannot form a write. Such a command skips memory and the write entirely and commits at once, so the issuing side is never blocked.

Top module: `mvin_engine`

## Requirements
- R1: After reset, `idle` and `cmd_ready` are 1 and `mem_req_valid`, `wr_valid` and `commit_valid` are 0.
- R2: The parameter word is decoded as follows. The bank is bits [4:0] and appears on `wr_bank`. The row count is bits [14:5] and appears on `wr_rows`. The stride is bits [33:15]. Bits [63:34] have no effect.
- R3: Memory reads are issued in ascending row order. The address of row `i` is `base + i*16*stride`, computed modulo 2^64 using all 64 bits of `base`. No new request is issued while a response is still awaited.
- R4: A stride field of 0 behaves exactly as a stride of 1, giving addresses that step by 16.
- R5: In `wr_data`, row `r` occupies bits `[r*128 +: 128]`. The low 64-bit word of a row holds the response's low word and the upper 64 bits hold its high word.
- R6: A row whose response has `mem_rsp_err` set is written as all zeros. The rows around it are unaffected.
- R7: `wr_valid` pulses for exactly one cycle, once per command, after the last response has been taken.
- R8: `commit_valid` pulses for one cycle with the command's tag exactly `LAT_PER_ROW * rows` cycles after the `wr_valid` cycle. `LAT_PER_ROW` is at least 1.
- R9: A command whose row count is 0 or greater than `ROWS_MAX` issues no memory read and no write. It commits in the cycle right after acceptance.
- R10: `cmd_ready` and `idle` are high only while the engine is idle. A command offered while the engine is busy is ignored.
- R11: In the cycle after a commit, the engine is idle again and can accept a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_base | input | 64 | Base memory address |
| cmd_param | input | 64 | Packed bank / rows / stride word |
| cmd_tag | input | TAG_W | Reorder tag |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read address of the current row |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_err | input | 1 | Read failed; row written as zero |
| mem_rsp_lo | input | 64 | Low word of the beat |
| mem_rsp_hi | input | 64 | High word of the beat |
| wr_valid | output | 1 | One-cycle bank write pulse |
| wr_bank | output | 5 | Destination bank |
| wr_rows | output | 10 | Number of valid rows |
| wr_data | output | ROWS_MAX*128 | Row data, row 0 in the lowest bits |
| commit_valid | output | 1 | One-cycle commit pulse |
| commit_tag | output | TAG_W | Tag of the committed command |
| idle | output | 1 | High only in the idle state |

## Verification
The bench builds the engine with `ROWS_MAX = 8`, `LAT_PER_ROW = 3` and `TAG_W = 6`. The small buffer puts the full-buffer case (8 rows) and the overflow case (9 rows) within a few dozen cycles. A latency of 3 makes the commit delay differ from the row count, so a timer that ignores the scaling is exposed. A large stride together with a base near the top of the address space exercises the 64-bit wrap, and injected read errors show the zeroed row.

// File: rtl/mvin_pkg.sv
// Shared constants, state encoding and parameter-word decoding for the
// move-in engine. Assumes the field layout of the packed parameter word
// is fixed by the issuing side.
package mvin_pkg;
    localparam int BEAT_W     = 128;
    localparam int WORD_W     = 64;
    localparam int ADDR_W     = 64;
    localparam int PARAM_W    = 64;
    localparam int BANK_LSB   = 0;
    localparam int BANK_W     = 5;
    localparam int ROWS_LSB   = 5;
    localparam int ROWS_W     = 10;
    localparam int STRIDE_LSB = 15;
    localparam int STRIDE_W   = 19;
    localparam int BEAT_SHIFT = 4;   // 16 bytes per beat

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ACTIVE,
        ST_DONE
    } mvin_state_e;

    typedef struct packed {
        logic [STRIDE_W-1:0] stride;
        logic [ROWS_W-1:0]   rows;
        logic [BANK_W-1:0]   bank;
    } mvin_fields_t;

    // Extract the fields; a zero stride is promoted to one.
    function automatic mvin_fields_t decode_param(input logic [PARAM_W-1:0] p);
        mvin_fields_t f;
        f.bank   = p[BANK_LSB   +: BANK_W];
        f.rows   = p[ROWS_LSB   +: ROWS_W];
        f.stride = p[STRIDE_LSB +: STRIDE_W];
        if (f.stride == '0) begin
            f.stride = STRIDE_W'(1);
        end
        return f;
    endfunction
endpackage

// File: rtl/mvin_addr_gen.sv
// Row address generator: base + row * 16 * stride, wrapping at 2^64.
// Assumes the stride given is already the effective (non-zero) stride.
module mvin_addr_gen #(
    parameter int ROW_W    = 10,
    parameter int STRIDE_W = 19
) (
    input  logic [63:0]         base,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [ROW_W-1:0]    row,
    output logic [63:0]         addr
);
    localparam int PROD_W = ROW_W + STRIDE_W;
    localparam int PAD_W  = 64 - PROD_W - mvin_pkg::BEAT_SHIFT;

    logic [PROD_W-1:0] prod;

    // Byte offset of the row, then add to the full-width base.
    always_comb begin
        prod = {{STRIDE_W{1'b0}}, row} * {{ROW_W{1'b0}}, stride};
        addr = base + {{PAD_W{1'b0}}, prod, {mvin_pkg::BEAT_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/mvin_row_buf.sv
// Row staging buffer: one write port, all rows visible on a flat bus.
// Assumes the write index stays below ROWS; contents are not reset.
module mvin_row_buf #(
    parameter int ROWS   = 16,
    parameter int BEAT_W = 128,
    localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [IDX_W-1:0]       widx,
    input  logic [BEAT_W-1:0]      wdata,
    output logic [ROWS*BEAT_W-1:0] flat
);
    logic [BEAT_W-1:0] mem [ROWS];

    // Capture one beat into its row slot.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign flat[r*BEAT_W +: BEAT_W] = mem[r];
    end
endmodule

// File: rtl/mvin_lat_timer.sv
// Down-counter for the modelled transfer latency. `last` is high in the
// final counted cycle. Assumes a load value of at least 1.
module mvin_lat_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Load on entry, decrement once per active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/mvin_engine.sv
// Strided move-in engine: decodes one command, fetches its rows one beat
// at a time, emits a single bank write pulse, waits LAT_PER_ROW cycles
// per row, then commits the tag. Assumes the memory returns at most one
// response per accepted request and the commit consumer is always ready.
module mvin_engine #(
    parameter int ROWS_MAX    = 16,
    parameter int LAT_PER_ROW = 1,
    parameter int TAG_W       = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [63:0]              cmd_base,
    input  logic [63:0]              cmd_param,
    input  logic [TAG_W-1:0]         cmd_tag,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [63:0]              mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic                     mem_rsp_err,
    input  logic [63:0]              mem_rsp_lo,
    input  logic [63:0]              mem_rsp_hi,
    output logic                     wr_valid,
    output logic [4:0]               wr_bank,
    output logic [9:0]               wr_rows,
    output logic [ROWS_MAX*128-1:0]  wr_data,
    output logic                     commit_valid,
    output logic [TAG_W-1:0]         commit_tag,
    output logic                     idle
);
    import mvin_pkg::*;

    localparam int IDX_W = (ROWS_MAX > 1) ? $clog2(ROWS_MAX) : 1;
    localparam int CNT_W = $clog2(LAT_PER_ROW * ROWS_MAX + 1) + 1;

    mvin_state_e         state_q;
    logic [63:0]         base_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [ROWS_W-1:0]   rows_q;
    logic [BANK_W-1:0]   bank_q;
    logic [TAG_W-1:0]    tag_q;
    logic [ROWS_W-1:0]   idx_q;
    logic                wait_rsp_q;
    logic                wr_valid_q;

    mvin_fields_t        fields;
    logic                accept;
    logic                fits;
    logic                rsp_take;
    logic                last_row;
    logic                timer_last;
    logic [BEAT_W-1:0]   beat;
    logic [CNT_W-1:0]    lat_load;

    // Decode the offered command and classify it.
    always_comb begin
        fields   = decode_param(cmd_param);
        fits     = (fields.rows != '0) && (32'(fields.rows) <= ROWS_MAX);
        accept   = cmd_valid && (state_q == ST_IDLE);
        rsp_take = (state_q == ST_FETCH) && wait_rsp_q && mem_rsp_valid;
        last_row = rsp_take && (idx_q == rows_q - 1'b1);
        beat     = mem_rsp_err ? '0 : {mem_rsp_hi, mem_rsp_lo};
        lat_load = CNT_W'(LAT_PER_ROW * 32'(rows_q));
    end

    // Command state and sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            stride_q   <= '0;
            rows_q     <= '0;
            bank_q     <= '0;
            tag_q      <= '0;
            idx_q      <= '0;
            wait_rsp_q <= 1'b0;
            wr_valid_q <= 1'b0;
        end else begin
            wr_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        base_q     <= cmd_base;
                        stride_q   <= fields.stride;
                        rows_q     <= fields.rows;
                        bank_q     <= fields.bank;
                        tag_q      <= cmd_tag;
                        idx_q      <= '0;
                        wait_rsp_q <= 1'b0;
                        state_q    <= fits ? ST_FETCH : ST_DONE;
                    end
                end
                ST_FETCH: begin
                    if (mem_req_valid && mem_req_ready) begin
                        wait_rsp_q <= 1'b1;
                    end
                    if (rsp_take) begin
                        wait_rsp_q <= 1'b0;
                        idx_q      <= idx_q + 1'b1;
                        if (last_row) begin
                            wr_valid_q <= 1'b1;
                            state_q    <= ST_ACTIVE;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (timer_last) begin
                        state_q <= ST_DONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    mvin_addr_gen #(
        .ROW_W    (ROWS_W),
        .STRIDE_W (STRIDE_W)
    ) u_addr (
        .base   (base_q),
        .stride (stride_q),
        .row    (idx_q),
        .addr   (mem_req_addr)
    );

    mvin_row_buf #(
        .ROWS   (ROWS_MAX),
        .BEAT_W (BEAT_W)
    ) u_buf (
        .clk   (clk),
        .we    (rsp_take),
        .widx  (idx_q[IDX_W-1:0]),
        .wdata (beat),
        .flat  (wr_data)
    );

    mvin_lat_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (last_row),
        .load_val (lat_load),
        .tick     (state_q == ST_ACTIVE),
        .last     (timer_last)
    );

    assign mem_req_valid = (state_q == ST_FETCH) && !wait_rsp_q;
    assign wr_valid      = wr_valid_q;
    assign wr_bank       = bank_q;
    assign wr_rows       = rows_q;
    assign commit_valid  = (state_q == ST_DONE);
    assign commit_tag    = tag_q;
    assign idle          = (state_q == ST_IDLE);
    assign cmd_ready     = idle;
endmodule

// File: rtl/mvin_engine_chk.sv
// Protocol checker for the move-in engine, attached by bind below.
module mvin_engine_chk #(
    parameter int ROWS_MAX = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       mem_req_valid,
    input logic       mem_req_ready,
    input logic       wr_valid,
    input logic [9:0] wr_rows,
    input logic       commit_valid,
    input logic       idle
);
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mem_req_valid && !wr_valid && !commit_valid)); // R10
    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !idle); // R10
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid); // R7
    AST_WR_ROWS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_rows != 10'd0 && 32'(wr_rows) <= ROWS_MAX)); // R9
    AST_COMMIT_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> (idle && !commit_valid)); // R11
endmodule

bind mvin_engine mvin_engine_chk #(.ROWS_MAX(ROWS_MAX)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .wr_valid      (wr_valid),
    .wr_rows       (wr_rows),
    .commit_valid  (commit_valid),
    .idle          (idle)
);

// File: tb/mvin_engine_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module mvin_engine_test;
    localparam int ROWS = 8;
    localparam int LAT  = 3;
    localparam int TW   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [63:0]       cmd_base = '0;
    logic [63:0]       cmd_param = '0;
    logic [TW-1:0]     cmd_tag = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic [63:0]       mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic              mem_rsp_err = 1'b0;
    logic [63:0]       mem_rsp_lo = '0;
    logic [63:0]       mem_rsp_hi = '0;
    logic              wr_valid;
    logic [4:0]        wr_bank;
    logic [9:0]        wr_rows;
    logic [ROWS*128-1:0] wr_data;
    logic              commit_valid;
    logic [TW-1:0]     commit_tag;
    logic              idle;

    int n_tests = 0;
    int n_fail  = 0;
    int n_req   = 0;
    int err_row = -1;
    logic [63:0] addr_log [64];

    always #4 clk = ~clk;

    mvin_engine #(.ROWS_MAX(ROWS), .LAT_PER_ROW(LAT), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
        .cmd_param(cmd_param), .cmd_tag(cmd_tag),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_lo(mem_rsp_lo), .mem_rsp_hi(mem_rsp_hi),
        .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_rows(wr_rows), .wr_data(wr_data),
        .commit_valid(commit_valid), .commit_tag(commit_tag), .idle(idle)
    );

    // Memory model: answers every accepted request one cycle later.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (n_req < 64) addr_log[n_req] <= mem_req_addr;
            mem_rsp_valid <= 1'b1;
            mem_rsp_err   <= (n_req == err_row);
            mem_rsp_lo    <= mem_req_addr ^ 64'h0123_4567_89AB_CDEF;
            mem_rsp_hi    <= ~mem_req_addr;
            n_req         <= n_req + 1;
        end
    end

    task automatic chk(input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_param(input logic [4:0] bank, input logic [9:0] rows,
                                             input logic [18:0] stride, input logic [29:0] junk);
        return {junk, stride, rows, bank};
    endfunction

    // Issue one command and check the whole transaction.
    task automatic run_cmd(input string rq_addr, input logic [63:0] base,
                           input logic [4:0] bank, input logic [9:0] rows,
                           input logic [18:0] stride, input logic [29:0] junk,
                           input logic [TW-1:0] tag, input int bad_row, input bit poke);
        logic [63:0] eff;
        logic [ROWS*128-1:0] cap;
        logic [4:0]  cap_bank;
        logic [9:0]  cap_rows;
        int  wr_seen = 0;
        int  t_wr = -1;
        int  t_cm = -1;
        logic [TW-1:0] cap_tag = '0;
        bit  fault;
        fault   = (rows == 0) || (rows > ROWS);
        eff     = (stride == 0) ? 64'd1 : {45'd0, stride};
        n_req   = 0;
        err_row = bad_row;
        cap = '0; cap_bank = '0; cap_rows = '0;
        cmd_base  = base;
        cmd_param = mk_param(bank, rows, stride, junk);
        cmd_tag   = tag;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (poke && cyc == 0) begin
                chk("R10", "ready while busy", {127'd0, cmd_ready}, 128'd0);
                cmd_valid = 1'b1;
                cmd_tag   = ~tag;
                cmd_param = mk_param(5'd1, 10'd1, 19'd1, 30'd0);
            end else if (poke && cyc == 1) begin
                cmd_valid = 1'b0;
            end
            if (wr_valid) begin
                wr_seen++;
                t_wr = cyc; cap = wr_data; cap_bank = wr_bank; cap_rows = wr_rows;
            end
            if (commit_valid) begin
                t_cm = cyc; cap_tag = commit_tag;
                break;
            end
            @(negedge clk);
        end
        chk("R8", "commit tag", {{(128-TW){1'b0}}, cap_tag}, {{(128-TW){1'b0}}, tag});
        if (fault) begin
            chk("R9", "reads issued", 128'(n_req), 128'd0);
            chk("R9", "writes issued", 128'(wr_seen), 128'd0);
            chk("R9", "commit cycle", 128'(t_cm), 128'd0);
        end else begin
            chk("R3", "read count", 128'(n_req), 128'(rows));
            for (int i = 0; i < int'(rows); i++) begin
                chk(rq_addr, "row address", {64'd0, addr_log[i]},
                    {64'd0, base + 64'(i) * 64'd16 * eff});
            end
            chk("R7", "write pulses", 128'(wr_seen), 128'd1);
            chk("R2", "bank", 128'(cap_bank), 128'(bank));
            chk("R2", "rows", 128'(cap_rows), 128'(rows));
            for (int i = 0; i < int'(rows); i++) begin
                logic [63:0] a;
                a = base + 64'(i) * 64'd16 * eff;
                if (i == bad_row)
                    chk("R6", "error row", cap[i*128 +: 128], 128'd0);
                else
                    chk("R5", "row data", cap[i*128 +: 128],
                        {~a, a ^ 64'h0123_4567_89AB_CDEF});
            end
            chk("R8", "latency", 128'(t_cm - t_wr), 128'(LAT * int'(rows)));
        end
        @(negedge clk);
        chk("R11", "idle after commit", {126'd0, idle, cmd_ready}, 128'd3);
        chk("R11", "single commit", {127'd0, commit_valid}, 128'd0);
        err_row = -1;
    endtask

    task automatic t_reset();
        chk("R1", "reset outputs",
            {123'd0, idle, cmd_ready, mem_req_valid, wr_valid, commit_valid},
            {123'd0, 5'b11000});
    endtask

    task automatic t_basic();
        run_cmd("R3", 64'h0000_0000_0000_1000, 5'd3, 10'd4, 19'd1, 30'd0, 6'h11, -1, 1'b0);
    endtask

    task automatic t_stride_and_junk();
        // R2: upper junk bits set; R3: full 64-bit base with stride 5
        run_cmd("R3", 64'hFFFF_FFFF_0000_0040, 5'd31, 10'd3, 19'd5, 30'h3FFF_FFFF, 6'h22, -1, 1'b0);
    endtask

    task automatic t_zero_stride();
        run_cmd("R4", 64'h0000_0000_0000_2000, 5'd7, 10'd2, 19'd0, 30'd0, 6'h05, -1, 1'b0);
    endtask

    task automatic t_full_wrap();
        // R3: maximum stride, base near top of the space, buffer full
        run_cmd("R3", 64'hFFFF_FFFF_FFFF_FF00, 5'd9, 10'd8, 19'h7FFFF, 30'd0, 6'h3F, -1, 1'b0);
    endtask

    task automatic t_error_row();
        run_cmd("R6", 64'h0000_0000_0001_0000, 5'd2, 10'd3, 19'd2, 30'd0, 6'h0A, 1, 1'b0);
    endtask

    task automatic t_faults();
        run_cmd("R9", 64'h0000_0000_0000_3000, 5'd4, 10'd0, 19'd1, 30'd0, 6'h13, -1, 1'b0);
        run_cmd("R9", 64'h0000_0000_0000_3000, 5'd4, 10'd9, 19'd1, 30'd0, 6'h14, -1, 1'b0);
    endtask

    task automatic t_busy();
        run_cmd("R10", 64'h0000_0000_0000_4000, 5'd6, 10'd2, 19'd3, 30'd0, 6'h2C, -1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stride_and_junk();
        t_zero_stride();
        t_full_wrap();
        t_error_row();
        t_faults();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule